// File: doc/BRIEF.md
# Fast page mode DRAM controller

This block connects a synchronous host to an asynchronous fast-page-mode DRAM organised as 4M locations of one bit each. The host issues one request at a time over a valid/ready port. Each request carries a 22-bit word address, a write flag and one data bit. Read data comes back with a one-cycle valid strobe. The controller splits the address into a row part and a column part and drives both, one after the other, on a shared address bus. It sequences the row strobe, the column strobe and the write enable. Every analog timing limit of the memory is given as a parameter in whole clock cycles.

After an access the row stays open, so a request that falls in the same row costs only a new column-strobe cycle. The row is closed, with the row strobe raised for the precharge time, in four cases: a request for a different row, a refresh request, the approach of the maximum page-mode row-strobe width, or the end of an access. Writes are always early writes, so the memory's data output never turns on during a write. Refresh itself is generated elsewhere. This block only parks the memory bus and grants it through a request/grant pair.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is applied and once it is released with no refresh pending, the row strobe, column strobe and write enable sit high, `rsp_valid` and `ref_gnt` are low, and `req_ready` is high.
- R2: The row address is `req_addr[21:11]` and is on the bus when the row strobe falls. The column address is `req_addr[10:0]` and is on the bus when the column strobe falls. It stays unchanged while the column strobe is low.
- R3: Each accepted read produces exactly one single-cycle `rsp_valid` pulse. Its `rsp_rdata` is the value most recently written to that address, or 0 if the address was never written. Responses return in request order.
- R4: A write drives the write enable low and the data bit one full cycle before the column strobe falls, keeps them until the column strobe rises, and produces no response.
- R5: A request to the open row is accepted without the row strobe rising. A read hit raises `rsp_valid` on the (1 + CAS_LEN)-th rising edge after the accepting edge, where CAS_LEN is the largest of T_CAS, T_CAC and T_AA-1.
- R6: A request to a different row closes the open row. The row strobe stays low at least T_RAS_MIN cycles and then stays high at least T_RP cycles before it falls again.
- R7: The column strobe is high whenever the row strobe falls. It falls only after the row strobe has been low at least T_RCD cycles, stays low at least CAS_LEN cycles, and stays high at least T_CP cycles between two accesses in the same row.
- R8: Read data is sampled only after the row strobe has been low T_RAC cycles, the column strobe low T_CAC cycles and the column address driven T_AA cycles.
- R9: A refresh request has priority over host requests. `ref_gnt` rises only after the row is closed, and while it is high both strobes stay high and `req_ready` is low. After `ref_req` falls, the next access opens its row again.
- R10: The row strobe never stays low for more than T_RASP_MAX cycles, even under a continuous stream of page hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 22 | Word address, row in the upper 11 bits |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 1 | Write data bit |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 1 | Read data bit |
| ref_req | input | 1 | External refresh engine wants the memory bus |
| ref_gnt | output | 1 | Bus parked and handed to the refresh engine |
| dram_addr | output | 11 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | 1 | Data to the memory |
| dram_dout | input | 1 | Data from the memory |

## Verification
The assertions assume that the host keeps `req_addr`, `req_we` and `req_wdata` steady while `req_valid` is high and not yet accepted, and that the refresh engine holds `ref_req` until it has been granted. The bench drivers change inputs only on falling clock edges. They hold each request until acceptance with one request outstanding, and they keep `ref_req` high until they see the grant. A cycle-level memory model answers with corrupted data if it is sampled before its access times have elapsed. Random traffic is spread over a few rows and a small column range, so page hits, page misses and read-after-write cases all occur often.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROWSET,
    ST_RASACT,
    ST_COLSET,
    ST_CASLOW,
    ST_CASPRE,
    ST_OPEN,
    ST_PRECH,
    ST_REFR
  } fpm_state_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpm_cnt.sv
`timescale 1ns/1ps
module fpm_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (en && (cnt != {W{1'b1}})) begin
      cnt_d = cnt + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/fpm_row_trk.sv
`timescale 1ns/1ps
module fpm_row_trk #(
  parameter int unsigned ROW_W = 11,
  parameter int unsigned COL_W = 11
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   close,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  output logic [ROW_W-1:0]       row_q,
  output logic [COL_W-1:0]       col_q,
  output logic                   hit
);

  localparam int unsigned ADDR_W = ROW_W + COL_W;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             open_q;
  logic             open_d;

  assign req_row = req_addr[ADDR_W-1 -: ROW_W];
  assign req_col = req_addr[COL_W-1:0];
  assign hit     = open_q && (req_row == row_q);

  always_comb begin
    open_d = open_q;
    if (close) begin
      open_d = 1'b0;
    end else if (load) begin
      open_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      open_q <= open_d;
      if (load) begin
        row_q <= req_row;
        col_q <= req_col;
      end
    end
  end

endmodule

// File: rtl/fpm_dram_ctrl.sv
`timescale 1ns/1ps
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int unsigned ROW_W      = 11,
  parameter int unsigned COL_W      = 11,
  parameter int unsigned T_RCD      = 1,
  parameter int unsigned T_RAC      = 3,
  parameter int unsigned T_CAC      = 1,
  parameter int unsigned T_AA       = 2,
  parameter int unsigned T_CAS      = 1,
  parameter int unsigned T_CP       = 1,
  parameter int unsigned T_RP       = 2,
  parameter int unsigned T_RAS_MIN  = 3,
  parameter int unsigned T_RASP_MAX = 10000
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      req_valid,
  output logic                                      req_ready,
  input  logic [ROW_W+COL_W-1:0]                    req_addr,
  input  logic                                      req_we,
  input  logic                                      req_wdata,
  output logic                                      rsp_valid,
  output logic                                      rsp_rdata,
  input  logic                                      ref_req,
  output logic                                      ref_gnt,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                                      dram_ras_n,
  output logic                                      dram_cas_n,
  output logic                                      dram_we_n,
  output logic                                      dram_din,
  input  logic                                      dram_dout
);

  localparam int unsigned BUS_W     = umax(ROW_W, COL_W);
  localparam int unsigned AA_LEN    = (T_AA > 1) ? T_AA - 1 : 1;
  localparam int unsigned CAS_LEN   = umax(umax(T_CAS, T_CAC), AA_LEN);
  localparam int unsigned PAGE_SPAN = 4 + CAS_LEN + T_CP;
  localparam int unsigned GUARD     = T_RASP_MAX - PAGE_SPAN;
  localparam int unsigned AGE_W     = $clog2(T_RASP_MAX + 1);
  localparam int unsigned PH_MAX    = umax(umax(T_RCD, CAS_LEN), umax(T_CP, T_RP));
  localparam int unsigned PH_W      = $clog2(PH_MAX + 2);

  localparam logic [PH_W-1:0]  RCD_END  = PH_W'(T_RCD - 1);
  localparam logic [PH_W-1:0]  CAS_END  = PH_W'(CAS_LEN - 1);
  localparam logic [PH_W-1:0]  CP_END   = PH_W'(T_CP - 1);
  localparam logic [PH_W-1:0]  RP_END   = PH_W'(T_RP - 1);
  localparam logic [AGE_W-1:0] RAC_AGE  = AGE_W'(T_RAC - 1);
  localparam logic [AGE_W-1:0] RMIN_AGE = AGE_W'(T_RAS_MIN - 1);
  localparam logic [AGE_W-1:0] GUARD_AGE = AGE_W'(GUARD);
  localparam logic [AGE_W-1:0] RASP_LIM = AGE_W'(T_RASP_MAX);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sn = rs_q[1];

  fpm_state_e       state_q, state_d;
  logic [PH_W-1:0]  ph_cnt;
  logic [AGE_W-1:0] ras_age;
  logic             ras_low;
  logic             accept;
  logic             close_row;
  logic             hit;
  logic             want_close;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q, wd_q;
  logic             rsp_valid_q, rsp_rdata_q;
  logic             rd_done;

  assign ras_low = (state_q == ST_RASACT) || (state_q == ST_COLSET) ||
                   (state_q == ST_CASLOW) || (state_q == ST_CASPRE) ||
                   (state_q == ST_OPEN);

  // time spent in the current state
  fpm_cnt #(.W(PH_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (state_d != state_q),
    .en    (1'b1),
    .cnt   (ph_cnt)
  );

  // time the row strobe has been low
  fpm_cnt #(.W(AGE_W)) u_ras_age (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr   (!ras_low),
    .en    (1'b1),
    .cnt   (ras_age)
  );

  fpm_row_trk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_row (
    .clk      (clk),
    .rst_n    (rst_sn),
    .load     (accept),
    .close    (close_row),
    .req_addr (req_addr),
    .row_q    (row_q),
    .col_q    (col_q),
    .hit      (hit)
  );

  assign accept    = req_valid && req_ready;
  assign close_row = (state_d == ST_PRECH) || (state_d == ST_REFR);

  always_comb begin
    state_d    = state_q;
    req_ready  = 1'b0;
    want_close = 1'b0;
    case (state_q)
      ST_IDLE: begin
        req_ready = !ref_req;
        if (ref_req) begin
          state_d = ST_REFR;
        end else if (req_valid) begin
          state_d = ST_ROWSET;
        end
      end
      ST_ROWSET: state_d = ST_RASACT;
      ST_RASACT: if (ph_cnt >= RCD_END) state_d = ST_COLSET;
      ST_COLSET: state_d = ST_CASLOW;
      ST_CASLOW: begin
        if ((ph_cnt >= CAS_END) && (wr_q || (ras_age >= RAC_AGE))) begin
          state_d = ST_CASPRE;
        end
      end
      ST_CASPRE: if (ph_cnt >= CP_END) state_d = ST_OPEN;
      ST_OPEN: begin
        want_close = ref_req || (ras_age >= GUARD_AGE) || (req_valid && !hit);
        req_ready  = hit && !ref_req && (ras_age < GUARD_AGE);
        if (want_close) begin
          if (ras_age >= RMIN_AGE) state_d = ST_PRECH;
        end else if (req_valid) begin
          state_d = ST_COLSET;
        end
      end
      ST_PRECH: if (ph_cnt >= RP_END) state_d = ST_IDLE;
      ST_REFR:  if (!ref_req) state_d = ST_PRECH;
      default:  state_d = ST_PRECH;
    endcase
  end

  assign rd_done = (state_q == ST_CASLOW) && (state_d == ST_CASPRE) && !wr_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q     <= ST_IDLE;
      wr_q        <= 1'b0;
      wd_q        <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rd_done;
      if (accept) begin
        wr_q <= req_we;
        wd_q <= req_wdata;
      end
      if (rd_done) begin
        rsp_rdata_q <= dram_dout;
      end
    end
  end

  assign dram_ras_n = !ras_low;
  assign dram_cas_n = (state_q != ST_CASLOW);
  assign dram_we_n  = !(wr_q && ((state_q == ST_COLSET) || (state_q == ST_CASLOW)));
  assign dram_din   = wd_q;
  assign dram_addr  = ((state_q == ST_IDLE) || (state_q == ST_ROWSET) || (state_q == ST_RASACT)) ?
                      BUS_W'(row_q) : BUS_W'(col_q);
  assign ref_gnt    = (state_q == ST_REFR);
  assign rsp_valid  = rsp_valid_q;
  assign rsp_rdata  = rsp_rdata_q;

  // R9: bus parked while granted
  p_gnt_parked_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    ref_gnt |-> (dram_ras_n && dram_cas_n));

  // R7: column strobe only inside a row cycle
  p_cas_in_row_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    !dram_cas_n |-> !dram_ras_n);

  // R10: page-mode row strobe width bound
  p_page_width_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    !dram_ras_n |-> (ras_age < RASP_LIM));

  // R4: write enable settled before the column strobe falls
  p_early_we_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(dram_cas_n) |-> $stable(dram_we_n));

  // R2: column address held while the column strobe is low
  p_col_hold_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));

  // R5: a request taken while the row is open keeps it open
  p_hit_keeps_row_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (accept && !dram_ras_n) |=> !dram_ras_n);

  // R3: a response follows a read column cycle
  p_rsp_after_read_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    rsp_valid |-> $past(!dram_cas_n && dram_we_n));

endmodule

// File: tb/fpm_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpm_dram_ctrl_tb_top;

  localparam int unsigned T_RCD      = 1;
  localparam int unsigned T_RAC      = 3;
  localparam int unsigned T_CAC      = 1;
  localparam int unsigned T_AA       = 2;
  localparam int unsigned T_CAS      = 1;
  localparam int unsigned T_CP       = 1;
  localparam int unsigned T_RP       = 2;
  localparam int unsigned T_RAS_MIN  = 3;
  localparam int unsigned T_RASP_MAX = 60;
  localparam int CAS_LEN_E = 1; // max(T_CAS, T_CAC, T_AA-1) for the values above

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we, req_wdata, ref_req;
  logic [21:0] req_addr;
  logic        req_ready, rsp_valid, rsp_rdata, ref_gnt;
  logic [10:0] dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_din;
  logic        dout_m;

  always #10 clk = ~clk;

  fpm_dram_ctrl #(.T_RASP_MAX(T_RASP_MAX)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ref_req(ref_req), .ref_gnt(ref_gnt),
    .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
    .dram_we_n(dram_we_n), .dram_din(dram_din), .dram_dout(dout_m)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- memory model ----------------
  bit          mem    [int unsigned];
  bit          shadow [int unsigned];
  bit          mon_on = 1'b0;
  logic [10:0] m_row, m_col;
  int          ras_cyc, cas_cyc, rhi_cyc, chi_cyc;
  int          ras_falls = 0;
  logic [21:0] exp_addr;
  bit          exp_we, exp_din;

  function automatic bit mem_rd(input int unsigned k);
    return mem.exists(k) ? mem[k] : 1'b0;
  endfunction

  always @(negedge dram_ras_n) begin
    if (mon_on) begin
      m_row = dram_addr;
      ras_falls++;
    end
  end

  always @(negedge dram_cas_n) begin
    if (mon_on) begin
      m_col = dram_addr;
      chk({m_row, m_col} == exp_addr, "R2 address", {m_row, m_col}, exp_addr);
      chk(dram_we_n == !exp_we, "R4 we at column strobe", dram_we_n, !exp_we);
      if (!dram_we_n) begin
        mem[{10'd0, m_row, m_col}] = dram_din;
        chk(dram_din == exp_din, "R4 write data", dram_din, exp_din);
      end
    end
  end

  // data is corrupted if sampled before the access times have passed (R8)
  always @(negedge clk) begin
    if (!dram_ras_n && !dram_cas_n && dram_we_n) begin
      if ((ras_cyc + 1 >= T_RAC) && (cas_cyc + 1 >= T_CAC) && (cas_cyc + 2 >= T_AA))
        dout_m <= mem_rd({10'd0, m_row, m_col});
      else
        dout_m <= ~mem_rd({10'd0, m_row, m_col});
    end else begin
      dout_m <= 1'b0;
    end
  end

  // strobe timing rules, sampled with the values of the cycle just ended
  always @(posedge clk) begin
    if (!rst_n) begin
      ras_cyc <= 0; cas_cyc <= 0; rhi_cyc <= 99; chi_cyc <= 99;
    end else begin
      if (mon_on) begin
        if (!dram_ras_n && ras_cyc == 0) begin
          chk(rhi_cyc >= T_RP, "R6 precharge", rhi_cyc, T_RP);
          chk(dram_cas_n, "R7 cas high at row strobe", dram_cas_n, 1);
        end
        if (dram_ras_n && ras_cyc > 0) begin
          chk(ras_cyc >= T_RAS_MIN, "R6 row strobe min", ras_cyc, T_RAS_MIN);
          chk(ras_cyc <= T_RASP_MAX, "R10 row strobe max", ras_cyc, T_RASP_MAX);
        end
        if (!dram_cas_n && cas_cyc == 0) begin
          chk(ras_cyc >= T_RCD, "R7 row to column delay", ras_cyc, T_RCD);
          chk(chi_cyc >= T_CP, "R7 column precharge", chi_cyc, T_CP);
        end
        if (dram_cas_n && cas_cyc > 0)
          chk(cas_cyc >= CAS_LEN_E, "R7 column strobe width", cas_cyc, CAS_LEN_E);
        if (ref_gnt)
          chk(dram_ras_n && dram_cas_n, "R9 parked during grant", {dram_ras_n, dram_cas_n}, 3);
      end
      ras_cyc <= dram_ras_n ? 0 : ras_cyc + 1;
      cas_cyc <= dram_cas_n ? 0 : cas_cyc + 1;
      rhi_cyc <= dram_ras_n ? rhi_cyc + 1 : 0;
      chi_cyc <= dram_ras_n ? 99 : (dram_cas_n ? chi_cyc + 1 : 0);
    end
  end

  // ---------------- host driver ----------------
  task automatic do_req(input logic [21:0] a, input bit we, input bit d);
    int  rf0;
    time t_acc;
    bit  got;
    bit  bad;
    bit  expv;
    int  lat;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    exp_addr = a; exp_we = we; exp_din = d;
    rf0   = ras_falls;
    t_acc = $time - 1;
    expv  = shadow.exists({10'd0, a}) ? shadow[{10'd0, a}] : 1'b0;
    if (we) shadow[{10'd0, a}] = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (!we) begin
      got = 1'b0;
      for (int i = 0; i < 200 && !got; i++) begin
        if (rsp_valid) got = 1'b1;
        else @(negedge clk);
      end
      chk(got, "R3 read response", got, 1);
      if (got) begin
        chk(rsp_rdata == expv, "R3 R8 read data", rsp_rdata, expv);
        lat = int'(($time - t_acc) / 20);
        if (ras_falls == rf0)
          chk(lat == 2 + CAS_LEN_E, "R5 hit latency", lat, 2 + CAS_LEN_E);
        @(negedge clk);
        chk(!rsp_valid, "R3 single-cycle response", rsp_valid, 0);
      end
    end else begin
      bad = 1'b0;
      repeat (4) begin
        @(negedge clk);
        if (rsp_valid) bad = 1'b1;
      end
      chk(!bad, "R4 no response to write", bad, 0);
    end
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rf;
    bit seen;
    logic [10:0] rows [3];
    void'($urandom(32'h1f2e3d4c));
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_wdata = 1'b0;
    req_addr = '0; ref_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes in reset",
        {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes after reset",
        {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    chk(!rsp_valid && !ref_gnt, "R1 outputs idle", {rsp_valid, ref_gnt}, 0);
    chk(req_ready, "R1 ready", req_ready, 1);

    // directed: write, read, then read hit
    do_req({11'd5, 11'd3}, 1'b1, 1'b1);
    do_req({11'd5, 11'd3}, 1'b0, 1'b0);
    rf = ras_falls;
    do_req({11'd5, 11'd3}, 1'b0, 1'b0);
    chk(ras_falls == rf, "R5 hit keeps row", ras_falls, rf);
    do_req({11'd5, 11'd9}, 1'b0, 1'b0); // never written: 0

    // page miss
    rf = ras_falls;
    do_req({11'd6, 11'd3}, 1'b1, 1'b0);
    chk(ras_falls == rf + 1, "R6 miss reopens row", ras_falls, rf + 1);

    // address extremes
    do_req(22'h3FFFFF, 1'b1, 1'b1);
    do_req(22'h000000, 1'b1, 1'b1);
    do_req(22'h3FFFFF, 1'b0, 1'b0);
    do_req(22'h000000, 1'b0, 1'b0);

    // refresh while a row is open
    do_req({11'd5, 11'd3}, 1'b0, 1'b0);
    @(negedge clk);
    ref_req = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 50 && !seen; i++) begin
      @(negedge clk);
      if (ref_gnt) seen = 1'b1;
    end
    chk(seen, "R9 grant", seen, 1);
    repeat (5) begin
      @(negedge clk);
      chk(!req_ready && ref_gnt && dram_ras_n, "R9 hold during grant",
          {req_ready, ref_gnt, dram_ras_n}, 3);
    end
    ref_req = 1'b0;
    rf = ras_falls;
    do_req({11'd5, 11'd3}, 1'b0, 1'b0);
    chk(ras_falls == rf + 1, "R9 row reopened after refresh", ras_falls, rf + 1);

    // continuous hits must still close the row in time
    rf = ras_falls;
    for (int i = 0; i < 40; i++) do_req({11'd9, 11'(i)}, (i % 3) == 0, i[0]);
    chk(ras_falls - rf >= 2, "R10 forced close", ras_falls - rf, 2);

    // random traffic over a few rows
    rows[0] = 11'd2; rows[1] = 11'h7FF; rows[2] = 11'h155;
    for (int i = 0; i < 300; i++) begin
      logic [10:0] r;
      logic [10:0] c;
      r = rows[$urandom_range(0, 2)];
      c = 11'($urandom_range(0, 15));
      do_req({r, c}, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end

    repeat (10) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule